// File: doc/BRIEF.md
# Bit-Sliced Pipelined Adder

This block adds two unsigned operands and a carry input with the carry chain broken by a register at every bit position. Each bit position has its own full-adder stage. Stage k adds operand bit k to the carry that stage k-1 registered on the previous cycle, then registers its own carry for stage k+1. The least significant position is added first, and the carry moves one stage up per clock.

Operand bits bound for stage k wait k cycles in an input skew line, so they reach the stage together with the carry from below. Sum bits leave the lower stages early and wait in output deskew lines, so all result bits of one operand pair appear on the same cycle. Bit 0 waits three extra cycles, and each higher bit waits one fewer. A new operand pair can be presented on every clock. The result appears a fixed four cycles later, with a valid flag that travels beside the data.

Top module: `bitslice_add_pipe`

## Requirements
- R1: For each pair accepted with `in_valid_i` high, the cycle on which `out_valid_o` is high shows `sum_o` equal to bits [3:0] of `a_i + b_i + cin_i`.
- R2: A pair captured on rising edge n appears on the outputs right after rising edge n+3. The outputs do not hold it after edge n+2, so the latency is four cycles.
- R3: Pairs presented on consecutive cycles come out on consecutive cycles, in the order they were presented, with no gaps.
- R4: `out_valid_o` equals `in_valid_i` delayed by four clock cycles. An idle input cycle gives an idle output cycle.
- R5: While `rst_ni` is low, `out_valid_o`, `sum_o` and `cout_o` are 0 at once, without waiting for a clock edge. After `rst_ni` is released, no pair that was in flight before the reset appears: `out_valid_o` stays low for four cycles unless new valid pairs arrive.
- R6: On a valid output cycle, `cout_o` equals bit 4 of `a_i + b_i + cin_i` for the same pair. A carry that ripples through every bit position (for example 0xF + 0x0 + 1 = 0x10) reaches the outputs without affecting the pairs just before or just after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair on this cycle is valid |
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| out_valid_o | output | 1 | Result on this cycle is valid |
| sum_o | output | 4 | Sum bits of the result |
| cout_o | output | 1 | Carry out of bit 3 |

## Verification
A skew or deskew register out of place puts bits of one pair into the same result as bits of a neighbouring pair. This appears as a wrong sum on the first cycle that two different pairs stand back to back, so back-to-back random pairs and full-ripple carries expose it within four cycles. A broken carry register spoils every pair whose carry must cross that position. A valid line of the wrong depth moves `out_valid_o` off the data by a cycle, and the first lone valid pair among idle cycles shows this. If reset misses any stage, a stale result or stale carry appears within four cycles of release.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (c & (a | b));
  endfunction

endpackage

// File: rtl/bsp_delay.sv
module bsp_delay #(
  parameter int unsigned DW    = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/bsp_bit_stage.sv
module bsp_bit_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_q_o,
  output logic carry_q_o
);
  import bsp_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q_o   <= 1'b0;
      carry_q_o <= 1'b0;
    end else begin
      sum_q_o   <= fa_sum(a_i, b_i, c_i);
      carry_q_o <= fa_carry(a_i, b_i, c_i);
    end
  end

endmodule

// File: rtl/bitslice_add_pipe.sv
module bitslice_add_pipe #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic             out_valid_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int unsigned LAT = WIDTH;

  logic [WIDTH:0]   carry_w;
  logic [WIDTH-1:0] a_skew, b_skew, sum_raw;

  assign carry_w[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    // align operand bit k with the carry arriving from stage k-1
    if (k == 0) begin : g_noskew
      assign a_skew[k] = a_i[k];
      assign b_skew[k] = b_i[k];
    end else begin : g_skew
      logic [1:0] ab_q;
      bsp_delay #(.DW(2), .DEPTH(k)) u_skew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   ({a_i[k], b_i[k]}),
        .q_o   (ab_q)
      );
      assign a_skew[k] = ab_q[1];
      assign b_skew[k] = ab_q[0];
    end

    bsp_bit_stage u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_i      (a_skew[k]),
      .b_i      (b_skew[k]),
      .c_i      (carry_w[k]),
      .sum_q_o  (sum_raw[k]),
      .carry_q_o(carry_w[k+1])
    );

    // hold early sum bits until the top stage finishes
    if (k == WIDTH - 1) begin : g_nodeskew
      assign sum_o[k] = sum_raw[k];
    end else begin : g_deskew
      bsp_delay #(.DW(1), .DEPTH(WIDTH - 1 - k)) u_deskew (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (sum_raw[k]),
        .q_o   (sum_o[k])
      );
    end
  end

  assign cout_o = carry_w[WIDTH];

  bsp_delay #(.DW(1), .DEPTH(LAT)) u_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_valid_i),
    .q_o   (out_valid_o)
  );

endmodule

// File: rtl/bitslice_add_pipe_chk.sv
module bitslice_add_pipe_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic             out_valid_o,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o
);

  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic           mdl_v [WIDTH];
  logic [WIDTH:0] mdl_r [WIDTH];
  logic [CW-1:0]  since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(WIDTH); i++) begin
        mdl_v[i] <= 1'b0;
        mdl_r[i] <= '0;
      end
      since_rst <= '0;
    end else begin
      mdl_v[0] <= in_valid_i;
      mdl_r[0] <= (WIDTH+1)'(a_i) + (WIDTH+1)'(b_i) + (WIDTH+1)'(cin_i);
      for (int i = 1; i < int'(WIDTH); i++) begin
        mdl_v[i] <= mdl_v[i-1];
        mdl_r[i] <= mdl_r[i-1];
      end
      if (since_rst != CW'(WIDTH)) since_rst <= since_rst + 1'b1;
    end
  end

  assert_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (sum_o == mdl_r[WIDTH-1][WIDTH-1:0]));

  assert_valid_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == mdl_v[WIDTH-1]);

  assert_no_stale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < CW'(WIDTH)) |-> !out_valid_o);

  assert_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (cout_o == mdl_r[WIDTH-1][WIDTH]));

endmodule

bind bitslice_add_pipe bitslice_add_pipe_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .out_valid_o(out_valid_o),
  .sum_o      (sum_o),
  .cout_o     (cout_o)
);

// File: tb/tb_bitslice_add_pipe.sv
module tb_bitslice_add_pipe;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [3:0] a_i = '0, b_i = '0;
  logic       cin_i = 1'b0;
  logic       out_valid_o;
  logic [3:0] sum_o;
  logic       cout_o;

  int n_chk = 0, n_fail = 0;
  logic [5:0] hist [4];  // {valid, cout, sum} expected per in-flight cycle

  // {a, b, cin, expected {cout,sum}}
  localparam logic [13:0] VEC [12] = '{
    {4'h0, 4'h0, 1'b0, 5'h00}, {4'hf, 4'h1, 1'b0, 5'h10},
    {4'hf, 4'hf, 1'b1, 5'h1f}, {4'h5, 4'ha, 1'b0, 5'h0f},
    {4'h5, 4'ha, 1'b1, 5'h10}, {4'h8, 4'h8, 1'b0, 5'h10},
    {4'h7, 4'h1, 1'b0, 5'h08}, {4'h3, 4'h4, 1'b1, 5'h08},
    {4'h9, 4'h6, 1'b0, 5'h0f}, {4'hc, 4'h5, 1'b1, 5'h12},
    {4'h0, 4'h0, 1'b1, 5'h01}, {4'he, 4'h3, 1'b0, 5'h11}
  };

  bitslice_add_pipe #(.WIDTH(4)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .out_valid_o(out_valid_o), .sum_o(sum_o), .cout_o(cout_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // check outputs of the pair sent four cycles ago, then drive the next pair
  task automatic step(input string tag, input logic v, input logic [3:0] a,
                      input logic [3:0] b, input logic c, input logic [4:0] exp);
    @(negedge clk_i);
    chk({tag, " R2 R4 valid"}, {5'b0, out_valid_o}, {5'b0, hist[3][5]});
    if (hist[3][5]) chk({tag, " R1 R6 result"}, {1'b0, cout_o, sum_o}, {1'b0, hist[3][4:0]});
    for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v ? {1'b1, exp} : 6'h0;
    in_valid_i = v;
    a_i = v ? a : 4'h0;
    b_i = v ? b : 4'h0;
    cin_i = v ? c : 1'b0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 4'h0, 4'h0, 1'b0, 5'h0);
  endtask

  task automatic send(input string tag, input logic [3:0] a, input logic [3:0] b, input logic c);
    step(tag, 1'b1, a, b, c, 5'(a) + 5'(b) + 5'(c));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = 6'h0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R5 reset outputs", {out_valid_o, cout_o, sum_o}, 6'h0);
    #2 rst_ni = 1'b1;

    // R1 R3: table walked back to back
    for (int i = 0; i < 12; i++)
      step("R3 table", 1'b1, VEC[i][13:10], VEC[i][9:6], VEC[i][5], VEC[i][4:0]);
    idle("R3 flush", 4);

    // R2: lone pair surrounded by idle cycles
    send("R2 lone", 4'h6, 4'h7, 1'b1);
    idle("R2 lone", 5);

    // R4: alternating valid
    for (int i = 0; i < 8; i++) begin
      send("R4 bubble", 4'(i * 3), 4'(15 - i), i[0]);
      idle("R4 bubble", 1);
    end
    idle("R4 flush", 4);

    // R6: full ripple carries between contrasting neighbours
    send("R6 ripple", 4'hf, 4'h0, 1'b1);
    send("R6 ripple", 4'h0, 4'h0, 1'b0);
    send("R6 ripple", 4'hf, 4'h0, 1'b1);
    send("R6 ripple", 4'hf, 4'hf, 1'b1);
    send("R6 ripple", 4'h1, 4'h0, 1'b0);
    send("R6 ripple", 4'h8, 4'h7, 1'b1);
    idle("R6 flush", 4);

    // R1 R3: random back to back
    for (int i = 0; i < 300; i++)
      send("R1 random", 4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)), 1'($urandom_range(1, 0)));
    idle("R1 flush", 4);

    // R5: reset while the pipeline is full
    for (int i = 0; i < 4; i++) send("R5 prefill", 4'hf, 4'h9, 1'b1);
    @(posedge clk_i);
    #3 rst_ni = 1'b0;
    #1 chk("R5 async clear", {out_valid_o, cout_o, sum_o}, 6'h0);
    in_valid_i = 1'b0; a_i = '0; b_i = '0; cin_i = 1'b0;
    for (int i = 0; i < 4; i++) hist[i] = 6'h0;
    @(negedge clk_i);
    chk("R5 held in reset", {out_valid_o, cout_o, sum_o}, 6'h0);
    #2 rst_ni = 1'b1;
    idle("R5 no stale", 5);
    send("R5 after reset", 4'h3, 4'h3, 1'b0);
    idle("R5 after reset", 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule